// File: doc/BRIEF.md
# Two-Word Burst Double-Rate Static Memory with Split Data Ports

This block emulates a small static memory that moves two words per command across the two edges of complementary clocks. It has a write data port and a separate read data port. A command is taken on every rising edge of clock K. An active-low strobe marks a valid command, and a direction bit picks read or write. A write command's two data words arrive one cycle after the command: the first on the next K rise and the second on the K# rise that follows it. Each word carries its own pair of active-low nibble enables.

A read command's two words leave on the output clocks C and C#, one and a half cycles after the command. An output-valid flag takes the place of a tri-state driver. While the flag is low, the read data is forced to zero. The burst always covers the aligned pair of words that holds the command address: the second word is the address with its lowest bit inverted. Commands may follow one another every cycle without gaps. A read issued just after a write to the same pair returns the freshly written words.

The block expects C to rise at the middle of each K cycle, with C# being the inverse of C. K# is the inverse of K. Reset is synchronous and active high.

Top module: `ddr_sio_sram`

## Requirements
- R1: While reset is high, and after it is released with no read in flight, dout_oe is 0 and dout is 0. Reset clears every memory word to 0x00.
- R2: A write loaded at the K rise of cycle t stores din into address A at the K rise of cycle t+1. It stores din into the paired address at the K# rise half a cycle later.
- R3: A read loaded at the K rise of cycle t drives word A on dout with dout_oe high from the C rise at t+1.5 cycles. It drives the paired word from the C# rise at t+2.
- R4: A K rise with ld_n high starts nothing. The read output phases that belong to that slot show dout_oe = 0 and dout = 0x00.
- R5: Nibble enable nsel[0] (active low) guards din[3:0], and nsel[1] guards din[7:4]. A nibble whose enable is 1 keeps its stored value.
- R6: The nibble enables are sampled separately with each of the two write words. A beat with both enables at 1 writes nothing.
- R7: The paired address is A with bit 0 inverted. A burst that starts at an odd address delivers A and then A-1.
- R8: A read loaded in the cycle after a write to the same pair returns the words of that write, merged under their nibble enables.
- R9: Commands may be loaded on consecutive K rises in any mix. When the second word of one write and the first word of the next write land on the same address, the later word overlays the earlier one nibble by nibble.
- R10: A read loaded in the cycle before a write to the same pair returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Command and first-beat write clock |
| clk_kn | input | 1 | Inverse of clk_k; second-beat write clock |
| clk_c | input | 1 | Output clock for the first read word |
| clk_cn | input | 1 | Inverse of clk_c; output clock for the second read word |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW (6) | Burst address |
| din | input | 8 | Write data for both beats |
| nsel | input | 2 | Active-low nibble write enables |
| dout | output | 8 | Read data; zero while not valid |
| dout_oe | output | 1 | Read data valid (stands in for output enable) |

## Verification
The bench aims at the half-cycle boundaries. If the read pipeline were a stage short or long, the wrong word, or zero, would show in the C or C# window. If the pair address were A+1 rather than a bit-0 flip, an odd-address burst would read a neighbour's data. If a read were not forwarded from a second beat that has not yet been committed, it would return stale data. Back-to-back writes that overlap on one word, with partial nibble enables, catch a merge that builds on the stale array word and so loses the earlier beat's nibbles. A read placed just before a write catches forwarding that reaches too far ahead.

// File: rtl/ddr2b_pkg.sv
`timescale 1ns/1ps
package ddr2b_pkg;
    localparam int unsigned DEF_DEPTH  = 64;
    localparam int unsigned DEF_LANES  = 2;
    localparam int unsigned DEF_LANE_W = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic load_n, input logic read_sel);
        if (load_n) return OP_IDLE;
        return read_sel ? OP_READ : OP_WRITE;
    endfunction
endpackage

// File: rtl/ddr2b_cmd.sv
`timescale 1ns/1ps
module ddr2b_cmd
    import ddr2b_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else begin
            op_q   <= decode_op(ld_n, rw);
            addr_q <= addr;
        end
    end
endmodule

// File: rtl/ddr2b_kn_cap.sv
`timescale 1ns/1ps
module ddr2b_kn_cap #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 4,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk_kn,
    input  logic             rst,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] nsel,
    output logic [DW-1:0]    d_q,
    output logic [LANES-1:0] nsel_q
);
    // Second-beat capture: free-running, the K domain decides whether to commit
    always_ff @(posedge clk_kn) begin
        if (rst) begin
            d_q    <= '0;
            nsel_q <= '1;
        end else begin
            d_q    <= din;
            nsel_q <= nsel;
        end
    end
endmodule

// File: rtl/ddr2b_array.sv
`timescale 1ns/1ps
module ddr2b_array
    import ddr2b_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 4,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [AW-1:0]    a,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] nsel,
    input  logic [DW-1:0]    b1_data,
    input  logic [LANES-1:0] b1_nsel,
    output logic [DW-1:0]    rd_w0,
    output logic [DW-1:0]    rd_w1,
    output logic             rd_vld,
    output logic             b1_pend
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] b1_addr;
    logic [AW-1:0] a_pair;
    logic [DW-1:0] b1_word, base0, base1;
    logic          hit0, hit1;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] sel_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++)
            if (!sel_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        return r;
    endfunction

    assign a_pair  = {a[AW-1:1], ~a[0]};
    // Second beat captured on K# but not yet committed: forward it
    assign b1_word = lane_merge(mem[b1_addr], b1_data, b1_nsel);
    assign hit0    = b1_pend && (b1_addr == a);
    assign hit1    = b1_pend && (b1_addr == a_pair);
    assign base0   = hit0 ? b1_word : mem[a];
    assign base1   = hit1 ? b1_word : mem[a_pair];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            b1_pend <= 1'b0;
            b1_addr <= '0;
            rd_vld  <= 1'b0;
            rd_w0   <= '0;
            rd_w1   <= '0;
        end else begin
            if (b1_pend) mem[b1_addr] <= b1_word;
            // first beat of a write lands last so it overlays an older second beat
            if (op == OP_WRITE) begin
                mem[a]  <= lane_merge(base0, din, nsel);
                b1_pend <= 1'b1;
                b1_addr <= a_pair;
            end else begin
                b1_pend <= 1'b0;
            end
            if (op == OP_READ) begin
                rd_w0  <= base0;
                rd_w1  <= base1;
                rd_vld <= 1'b1;
            end else begin
                rd_vld <= 1'b0;
            end
        end
    end

    p_pair_addr_r7: assert property (@(posedge clk) disable iff (rst)
        b1_pend |-> (b1_addr[0] != $past(a[0])) && (b1_addr[AW-1:1] == $past(a[AW-1:1])));
    p_beat1_src_r2: assert property (@(posedge clk) disable iff (rst)
        b1_pend |-> ($past(op) == OP_WRITE));
endmodule

// File: rtl/ddr2b_out.sv
`timescale 1ns/1ps
module ddr2b_out #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_c,
    input  logic          clk_cn,
    input  logic          rst,
    input  logic [DW-1:0] rd_w0,
    input  logic [DW-1:0] rd_w1,
    input  logic          rd_vld,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    logic [DW-1:0] q0, q1;
    logic          oe0, oe1;

    always_ff @(posedge clk_c) begin
        if (rst) begin
            q0  <= '0;
            oe0 <= 1'b0;
        end else begin
            q0  <= rd_vld ? rd_w0 : '0;
            oe0 <= rd_vld;
        end
    end

    always_ff @(posedge clk_cn) begin
        if (rst) begin
            q1  <= '0;
            oe1 <= 1'b0;
        end else begin
            q1  <= rd_vld ? rd_w1 : '0;
            oe1 <= rd_vld;
        end
    end

    // Output phase select: C high shows the first word, C low the second
    assign dout    = clk_c ? q0 : q1;
    assign dout_oe = clk_c ? oe0 : oe1;
endmodule

// File: rtl/ddr_sio_sram.sv
`timescale 1ns/1ps
module ddr_sio_sram
    import ddr2b_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned LANE_W = DEF_LANE_W,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk_k,
    input  logic             clk_kn,
    input  logic             clk_c,
    input  logic             clk_cn,
    input  logic             rst,
    input  logic             ld_n,
    input  logic             rw,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] nsel,
    output logic [DW-1:0]    dout,
    output logic             dout_oe
);
    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    kn_d;
    logic [LANES-1:0] kn_nsel;
    logic [DW-1:0]    rd_w0, rd_w1;
    logic             rd_vld, b1_pend;

    ddr2b_cmd #(.AW(AW)) u_cmd (
        .clk(clk_k), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr),
        .op_q(op_q), .addr_q(addr_q)
    );

    ddr2b_kn_cap #(.LANES(LANES), .LANE_W(LANE_W)) u_kn (
        .clk_kn(clk_kn), .rst(rst), .din(din), .nsel(nsel),
        .d_q(kn_d), .nsel_q(kn_nsel)
    );

    ddr2b_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk_k), .rst(rst), .op(op_q), .a(addr_q), .din(din), .nsel(nsel),
        .b1_data(kn_d), .b1_nsel(kn_nsel),
        .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_vld(rd_vld), .b1_pend(b1_pend)
    );

    ddr2b_out #(.DW(DW)) u_out (
        .clk_c(clk_c), .clk_cn(clk_cn), .rst(rst),
        .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_vld(rd_vld),
        .dout(dout), .dout_oe(dout_oe)
    );

    p_rst_idle_r1: assert property (@(posedge clk_k)
        rst |=> (!rd_vld && !b1_pend));
    p_read_fetch_r3: assert property (@(posedge clk_k) disable iff (rst)
        (!ld_n && rw) |=> ##1 rd_vld);
    p_nop_quiet_r4: assert property (@(posedge clk_k) disable iff (rst)
        ld_n |=> ##1 (!rd_vld && !b1_pend));
    p_beat1_follows_r2: assert property (@(posedge clk_k) disable iff (rst)
        (!ld_n && !rw) |=> ##1 b1_pend);
endmodule

// File: tb/tb_ddr_sio_sram.sv
`timescale 1ns/1ps
module tb_ddr_sio_sram;
    localparam int AW = 6;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic clk_k, clk_kn, clk_c, clk_cn;
    assign clk_k  = clk;
    assign clk_kn = ~clk;
    assign clk_c  = ~clk;     // C rises mid-cycle of K
    assign clk_cn = clk;

    logic          rst, ld_n, rw;
    logic [AW-1:0] addr;
    logic [7:0]    din, dout;
    logic [1:0]    nsel;
    logic          dout_oe;

    ddr_sio_sram dut (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr), .din(din), .nsel(nsel),
        .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        int       cyc;
        bit       rd;
        logic [7:0] w0;
        logic [7:0] w1;
        string    tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] model [DEPTH];
    int checks = 0, fails = 0, cyc = 0;

    bit         p_wr = 0;
    logic [AW-1:0] p_a;
    logic [7:0] p_d0, p_d1;
    logic [1:0] p_s0, p_s1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] merge(input logic [7:0] o, input logic [7:0] n, input logic [1:0] s);
        logic [7:0] r;
        r = o;
        if (!s[0]) r[3:0] = n[3:0];
        if (!s[1]) r[7:4] = n[7:4];
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual oe/data=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // driver: op 0 = nop, 1 = write, 2 = read
    task automatic issue(input int op, input logic [AW-1:0] a,
                         input logic [7:0] d0, input logic [1:0] s0,
                         input logic [7:0] d1, input logic [1:0] s1, input string tag);
        exp_t e;
        @(negedge clk); #1.25;
        if (p_wr) begin
            model[p_a] = merge(model[p_a], p_d0, p_s0);
            model[p_a ^ 6'd1] = merge(model[p_a ^ 6'd1], p_d1, p_s1);
        end
        e.cyc = cyc + 1;
        e.rd  = (op == 2);
        e.w0  = model[a];
        e.w1  = model[a ^ 6'd1];
        e.tag = tag;
        sb.push_back(e);
        ld_n = (op == 0);
        rw   = (op == 2);
        addr = a;
        din  = p_wr ? p_d0 : 8'h5A;
        nsel = p_wr ? p_s0 : 2'b00;
        @(posedge clk); #1.25;
        din  = p_wr ? p_d1 : 8'hC3;
        nsel = p_wr ? p_s1 : 2'b00;
        p_wr = (op == 1);
        p_a = a; p_d0 = d0; p_s0 = s0; p_d1 = d1; p_s1 = s1;
    endtask

    // monitor: second word in C# window, first word in C window
    initial begin : monitor
        exp_t held;
        bit   have = 0;
        forever begin
            @(posedge clk); #1.25;
            if (have) begin
                chk(held.tag, "word1", {dout_oe, dout}, held.rd ? {1'b1, held.w1} : 9'h000);
                have = 0;
            end
            #2.5;
            if (sb.size() > 0 && sb[0].cyc == cyc - 1) begin
                held = sb.pop_front();
                have = 1;
                chk(held.tag, "word0", {dout_oe, dout}, held.rd ? {1'b1, held.w0} : 9'h000);
            end
        end
    end

    initial begin : watchdog
        #(20000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        rst = 1; ld_n = 1; rw = 0; addr = '0; din = '0; nsel = 2'b11;
        repeat (4) @(posedge clk);
        #1.25;
        chk("R1", "during reset C#", {dout_oe, dout}, 9'h000);
        #2.5;
        chk("R1", "during reset C", {dout_oe, dout}, 9'h000);
        @(negedge clk); #1.25 rst = 0;
        @(posedge clk); #1.25;
        chk("R1", "after reset C#", {dout_oe, dout}, 9'h000);
        #2.5;
        chk("R1", "after reset C", {dout_oe, dout}, 9'h000);

        issue(2, 6'd10, 0, 0, 0, 0, "R1");              // cleared memory reads zero
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(1, 6'd8, 8'h3C, 2'b00, 8'hA7, 2'b00, "R2");
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(2, 6'd8, 0, 0, 0, 0, "R3");
        issue(2, 6'd9, 0, 0, 0, 0, "R7");
        issue(1, 6'd13, 8'h6E, 2'b00, 8'h91, 2'b00, "R7");
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(2, 6'd12, 0, 0, 0, 0, "R7");
        // nibble enables
        issue(1, 6'd20, 8'h12, 2'b00, 8'h34, 2'b00, "R5");
        issue(1, 6'd20, 8'hAB, 2'b10, 8'hCD, 2'b01, "R5");
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(2, 6'd20, 0, 0, 0, 0, "R5");
        // per-beat enables: first beat blocked
        issue(1, 6'd30, 8'hEE, 2'b11, 8'h5D, 2'b00, "R6");
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(2, 6'd30, 0, 0, 0, 0, "R6");
        // forwarding: read right after write to same pair
        issue(1, 6'd40, 8'h4F, 2'b00, 8'hB2, 2'b00, "R8");
        issue(2, 6'd40, 0, 0, 0, 0, "R8");
        issue(1, 6'd41, 8'h77, 2'b01, 8'h88, 2'b10, "R8");
        issue(2, 6'd41, 0, 0, 0, 0, "R8");
        // read then write: old contents
        issue(2, 6'd8, 0, 0, 0, 0, "R10");
        issue(1, 6'd8, 8'hD1, 2'b00, 8'hE2, 2'b00, "R10");
        issue(0, 0, 0, 0, 0, 0, "R4");
        issue(2, 6'd8, 0, 0, 0, 0, "R10");
        // overlapping back-to-back writes
        issue(1, 6'd5, 8'h11, 2'b00, 8'h22, 2'b00, "R9");
        issue(1, 6'd4, 8'h9F, 2'b01, 8'h77, 2'b00, "R9");
        issue(2, 6'd4, 0, 0, 0, 0, "R9");
        issue(2, 6'd5, 0, 0, 0, 0, "R9");

        lf = 16'hACE1;
        for (int n = 0; n < 160; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue((lf[1:0] == 2'd0) ? 0 : (lf[1:0] == 2'd1) ? 1 : 2,
                  {2'b00, lf[5:2]}, lf[15:8], lf[9:8], lf[7:0] ^ 8'h3B, lf[11:10], "R9");
        end
        repeat (3) issue(0, 0, 0, 0, 0, 0, "R4");
        repeat (4) @(posedge clk);
        #4;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule